// File: doc/BRIEF.md
# Temperature Alert Latch and Alert-Response Responder

This block keeps the interrupt state of a temperature-monitoring slave on a shared two-wire management bus. After each completed conversion it takes three comparison results: reading above the high limit, reading below the low limit, and remote sensor fault. It turns a fresh crossing of any of them into a latched request. While the request is latched the block pulls the shared active-low, open-drain alert line low.

The host services the line by issuing a read to the bus-wide Alert Response Address. Every slave with a latched request acknowledges and then returns its own 7-bit address, MSB first. Arbitration is wired-AND, so the lowest address wins. A slave that releases the line but sees it held low withdraws. Only the winner's latch clears, and losers keep the line pulled low. Clearing status flags elsewhere has no effect on the latch. Each threshold fires once per crossing and must be re-armed by rewriting its limit register.

The byte engine, register file and converter are outside this block. It sees a reduced bit-serial bus view: a start strobe, a stop strobe, a per-bit strobe, and the resolved SDA level at that strobe. It answers with an open-drain pull-down request on SDA.

Top module: `alert_responder_top`

## Requirements
- R1: Reset clears the latch and releases SDA. When `conv_done` is high with an armed condition flag (`temp_high`, `temp_low` or `diode_fault`) and `alert_mask` low, `alert_pull_low` reads 1 from the next clock edge on.
- R2: Once set, `alert_pull_low` stays 1 through any number of further conversions. It drops only at the clock edge of the last data-bit strobe of an Alert Response read that this slave wins.
- R3: Bits after a start are numbered from 1 on `bit_strobe`: bits 1 to 7 carry the address MSB first, bit 8 is R/W (1 = read), bit 9 is the acknowledge, bits 10 to 17 are the data byte and bit 18 is the master acknowledge. When the address is 7'b0001100, R/W is 1 and the latch is set, the block pulls SDA low for bit 9. For bits 10 to 16 it pulls low exactly where its own address bit (MSB first) is 0, and it releases bit 17, which is a logic 1.
- R4: During bits 10 to 17, if the block released SDA but samples it low, it releases SDA for the rest of the transfer, does not clear its latch, and keeps `alert_pull_low` at 1.
- R5: An address other than 7'b0001100, or R/W = 0, causes no SDA pull-down at any bit and leaves the latch unchanged.
- R6: The high and low conditions fire once per crossing. After firing, further conversions with the same flag set nothing until the matching limit write strobe (`high_lim_wr` or `low_lim_wr`) re-arms that condition.
- R7: The fault condition fires once per fault episode. It re-arms after a conversion that reports no fault.
- R8: While `alert_mask` is 1, no conversion sets the latch and no condition's arming is consumed. A latch that is already set stays set.
- R9: The response address is the value of `own_addr_in` sampled while `rst` is high. Later changes on that input do not alter the returned address.
- R10: A stop strobe abandons a transfer in progress, and a start strobe (including a repeated start) restarts bit numbering at bit 1.
- R11: With the latch clear, an Alert Response read gets no acknowledge and no data from the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also samples the own address |
| own_addr_in | input | 7 | Strapped slave address, sampled during reset |
| conv_done | input | 1 | One-cycle strobe: a conversion finished and its flags are valid |
| temp_high | input | 1 | Conversion result above the high limit |
| temp_low | input | 1 | Conversion result below the low limit |
| diode_fault | input | 1 | Remote sensor path found open or shorted |
| high_lim_wr | input | 1 | Strobe: high limit register rewritten |
| low_lim_wr | input | 1 | Strobe: low limit register rewritten |
| alert_mask | input | 1 | Configuration mask blocking new alert events |
| bus_start | input | 1 | Start or repeated-start condition seen |
| bus_stop | input | 1 | Stop condition seen |
| bit_strobe | input | 1 | One-cycle strobe at the SCL sample point of each bit |
| sda_in | input | 1 | Resolved SDA level at the sample point |
| sda_pull_low | output | 1 | Request to pull SDA low for the current bit |
| alert_pull_low | output | 1 | Request to pull the shared alert line low |

## Verification
The bench sweeps all 128 master addresses with the latch set. Acknowledging anything besides the Alert Response read, or clearing on it, would show up as a stray pull-down or a dropped alert. It repeats winning reads under several strapped addresses and checks every returned bit, which exposes bit-order and off-by-one errors in the data phase. It pits the block against a modelled second slave with the next lower address. A design that ignores arbitration would keep driving and clear its own latch. It also re-drives a persisting flag, a mask held during a crossing and a fault that clears and returns. A design with the wrong arming rules would then fire repeatedly, fire never, or lose the event.

// File: rtl/alert_resp_pkg.sv
package alert_resp_pkg;

  // Condition channels: limit comparisons first, then fault sources.
  localparam int NUM_LIMITS = 2;
  localparam int NUM_FAULTS = 1;
  localparam int NUM_CH     = NUM_LIMITS + NUM_FAULTS;

  // How a channel becomes eligible to fire again after it has fired.
  typedef enum logic {
    ARM_ON_WRITE = 1'b0,  // re-armed by rewriting its limit register
    ARM_ON_CLEAN = 1'b1   // re-armed by a conversion without the condition
  } arm_kind_e;

  function automatic arm_kind_e kind_of(input int ch, input int n_limits);
    return (ch < n_limits) ? ARM_ON_WRITE : ARM_ON_CLEAN;
  endfunction

endpackage

// File: rtl/alert_arm_unit.sv
// Per-condition arming: a condition produces an event only on the first
// conversion that reports it after being armed.
module alert_arm_unit
  import alert_resp_pkg::*;
#(
  parameter int N_LIM   = NUM_LIMITS,
  parameter int N_FLT   = NUM_FAULTS,
  localparam int N_CH   = N_LIM + N_FLT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_done,
  input  logic             mask,
  input  logic [N_CH-1:0]  cond,
  input  logic [N_LIM-1:0] lim_wr,
  output logic             evt_any
);

  logic [N_CH-1:0] armed_q;
  logic [N_CH-1:0] fire;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    // Masked conversions neither fire nor consume arming.
    assign fire[ch] = conv_done && !mask && cond[ch] && armed_q[ch];

    if (kind_of(ch, N_LIM) == ARM_ON_WRITE) begin : g_wr
      always_ff @(posedge clk) begin
        if (rst)             armed_q[ch] <= 1'b1;
        else if (lim_wr[ch]) armed_q[ch] <= 1'b1;
        else if (fire[ch])   armed_q[ch] <= 1'b0;
      end
    end else begin : g_clean
      always_ff @(posedge clk) begin
        if (rst)                          armed_q[ch] <= 1'b1;
        else if (conv_done && !cond[ch])  armed_q[ch] <= 1'b1;
        else if (fire[ch])                armed_q[ch] <= 1'b0;
      end
    end
  end

  assign evt_any = |fire;

endmodule

// File: rtl/alert_latch.sv
// Sticky interrupt request. A new event wins over a clear in the same cycle.
module alert_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr_win,
  output logic pending
);

  always_ff @(posedge clk) begin
    if (rst)          pending <= 1'b0;
    else if (set_evt) pending <= 1'b1;
    else if (clr_win) pending <= 1'b0;
  end

endmodule

// File: rtl/ara_responder.sv
// Bit-level responder for the Alert Response Address read, with wired-AND
// arbitration during the returned address byte.
module ara_responder #(
  parameter int                ADDR_W   = 7,
  parameter logic [ADDR_W-1:0] ARA_ADDR = 7'b0001100,
  localparam int ACK_IDX    = ADDR_W + 1,          // strobe index of acknowledge
  localparam int DATA_FIRST = ACK_IDX + 1,         // first returned bit
  localparam int DATA_LAST  = DATA_FIRST + ADDR_W, // trailing logic-1 bit
  localparam int END_IDX    = DATA_LAST + 2,       // after master acknowledge
  localparam int CNT_W      = $clog2(END_IDX + 1),
  localparam int IDX_W      = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              pending,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              bit_strobe,
  input  logic              bus_sda,
  output logic              sda_low,
  output logic              win,
  output logic              lost
);

  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;
  logic              engaged_q;
  logic              lost_q;
  logic              sda_low_q;
  logic [ADDR_W-1:0] rx_q;

  logic step;
  logic eng_d, lost_d, drive_d, win_c;

  assign step = bit_strobe && busy_q && (cnt_q != CNT_W'(END_IDX));

  always_comb begin
    int pos;
    int nb;
    int bi;
    pos     = int'(cnt_q);
    nb      = pos + 1;
    bi      = 0;
    eng_d   = engaged_q;
    lost_d  = lost_q;
    drive_d = sda_low_q;
    win_c   = 1'b0;
    if (step) begin
      drive_d = 1'b0;
      // R/W bit: decide whether to take part in this transfer.
      if (pos == ACK_IDX - 1)
        eng_d = pending && (rx_q == ARA_ADDR) && bus_sda;
      // Arbitration: released but line low means another slave owns it.
      if (pos >= DATA_FIRST && pos <= DATA_LAST &&
          engaged_q && !lost_q && !sda_low_q && !bus_sda)
        lost_d = 1'b1;
      // Drive value for the next bit.
      if (nb == ACK_IDX) begin
        drive_d = eng_d;
      end else if (nb >= DATA_FIRST && nb < DATA_LAST) begin
        bi      = ADDR_W - 1 - (nb - DATA_FIRST);
        drive_d = eng_d && !lost_d && !own_addr[IDX_W'(bi)];
      end
      if (pos == DATA_LAST)
        win_c = engaged_q && !lost_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      engaged_q <= 1'b0;
      lost_q    <= 1'b0;
      sda_low_q <= 1'b0;
      rx_q      <= '0;
    end else if (bus_start) begin
      busy_q    <= 1'b1;
      cnt_q     <= '0;
      engaged_q <= 1'b0;
      lost_q    <= 1'b0;
      sda_low_q <= 1'b0;
      rx_q      <= '0;
    end else if (bus_stop) begin
      busy_q    <= 1'b0;
      engaged_q <= 1'b0;
      lost_q    <= 1'b0;
      sda_low_q <= 1'b0;
    end else if (step) begin
      cnt_q     <= cnt_q + 1'b1;
      if (cnt_q < CNT_W'(ACK_IDX - 1))
        rx_q <= {rx_q[ADDR_W-2:0], bus_sda};
      engaged_q <= eng_d;
      lost_q    <= lost_d;
      sda_low_q <= drive_d;
    end
  end

  assign sda_low = sda_low_q;
  assign win     = win_c;
  assign lost    = lost_q;

endmodule

// File: rtl/alert_responder_top.sv
module alert_responder_top
  import alert_resp_pkg::*;
#(
  parameter int                ADDR_W   = 7,
  parameter logic [ADDR_W-1:0] ARA_ADDR = 7'b0001100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] own_addr_in,
  input  logic              conv_done,
  input  logic              temp_high,
  input  logic              temp_low,
  input  logic              diode_fault,
  input  logic              high_lim_wr,
  input  logic              low_lim_wr,
  input  logic              alert_mask,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              bit_strobe,
  input  logic              sda_in,
  output logic              sda_pull_low,
  output logic              alert_pull_low
);

  logic [ADDR_W-1:0] own_q;
  logic              evt_any;
  logic              ara_win;
  logic              ara_lost;

  // Strapped address is captured while reset is held and kept thereafter.
  always_ff @(posedge clk) begin
    if (rst) own_q <= own_addr_in;
  end

  alert_arm_unit #(
    .N_LIM (NUM_LIMITS),
    .N_FLT (NUM_FAULTS)
  ) u_arm (
    .clk       (clk),
    .rst       (rst),
    .conv_done (conv_done),
    .mask      (alert_mask),
    .cond      ({diode_fault, temp_low, temp_high}),
    .lim_wr    ({low_lim_wr, high_lim_wr}),
    .evt_any   (evt_any)
  );

  alert_latch u_latch (
    .clk     (clk),
    .rst     (rst),
    .set_evt (evt_any),
    .clr_win (ara_win),
    .pending (alert_pull_low)
  );

  ara_responder #(
    .ADDR_W   (ADDR_W),
    .ARA_ADDR (ARA_ADDR)
  ) u_resp (
    .clk        (clk),
    .rst        (rst),
    .own_addr   (own_q),
    .pending    (alert_pull_low),
    .bus_start  (bus_start),
    .bus_stop   (bus_stop),
    .bit_strobe (bit_strobe),
    .bus_sda    (sda_in),
    .sda_low    (sda_pull_low),
    .win        (ara_win),
    .lost       (ara_lost)
  );

endmodule

// File: rtl/alert_responder_chk.sv
module alert_responder_chk (
  input logic clk,
  input logic rst,
  input logic alert_mask,
  input logic evt_any,
  input logic ara_win,
  input logic ara_lost,
  input logic sda_pull_low,
  input logic alert_pull_low
);

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
    evt_any |=> alert_pull_low); // R1

  AST_ALERT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    alert_pull_low && !ara_win |=> alert_pull_low); // R2

  AST_WIN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ara_win && !evt_any |=> !alert_pull_low); // R2

  AST_DRIVE_NEEDS_ALERT: assert property (@(posedge clk) disable iff (rst)
    sda_pull_low |-> alert_pull_low); // R3

  AST_LOSER_QUIET: assert property (@(posedge clk) disable iff (rst)
    ara_lost |-> !sda_pull_low); // R4

  AST_LOSER_NO_WIN: assert property (@(posedge clk) disable iff (rst)
    ara_lost |-> !ara_win); // R4

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    alert_mask && !alert_pull_low |=> !alert_pull_low); // R8

endmodule

bind alert_responder_top alert_responder_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .alert_mask     (alert_mask),
  .evt_any        (evt_any),
  .ara_win        (ara_win),
  .ara_lost       (ara_lost),
  .sda_pull_low   (sda_pull_low),
  .alert_pull_low (alert_pull_low)
);

// File: tb/test_alert_responder_top.sv
`timescale 1ns/1ps
module test_alert_responder_top;

  localparam logic [6:0] ARA = 7'b0001100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] own_addr_in = 7'h4D;
  logic conv_done = 0, temp_high = 0, temp_low = 0, diode_fault = 0;
  logic high_lim_wr = 0, low_lim_wr = 0, alert_mask = 0;
  logic bus_start = 0, bus_stop = 0, bit_strobe = 0;
  logic m_low = 0, o_low = 0;
  logic sda_in;
  logic sda_pull_low, alert_pull_low;

  int checks = 0;
  int errors = 0;
  logic [8:0] drv;

  always #10 clk = ~clk;

  assign sda_in = ~(m_low | o_low | sda_pull_low);

  alert_responder_top i_alert_responder_top (
    .clk(clk), .rst(rst), .own_addr_in(own_addr_in),
    .conv_done(conv_done), .temp_high(temp_high), .temp_low(temp_low),
    .diode_fault(diode_fault), .high_lim_wr(high_lim_wr),
    .low_lim_wr(low_lim_wr), .alert_mask(alert_mask),
    .bus_start(bus_start), .bus_stop(bus_stop), .bit_strobe(bit_strobe),
    .sda_in(sda_in), .sda_pull_low(sda_pull_low),
    .alert_pull_low(alert_pull_low));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [6:0] own);
    @(negedge clk);
    own_addr_in = own;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic convert(input logic h, input logic l, input logic f);
    @(negedge clk);
    temp_high = h; temp_low = l; diode_fault = f; conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0; temp_high = 0; temp_low = 0; diode_fault = 0;
  endtask

  task automatic pulse_hi_wr();
    @(negedge clk); high_lim_wr = 1'b1; @(negedge clk); high_lim_wr = 1'b0;
  endtask

  task automatic pulse_lo_wr();
    @(negedge clk); low_lim_wr = 1'b1; @(negedge clk); low_lim_wr = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk); bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
  endtask

  // One bus bit: master and second slave drive, block's pull-down recorded.
  task automatic one_bit(input logic ml, input logic ol, output logic dl, output logic line);
    @(negedge clk);
    m_low = ml; o_low = ol;
    #1;
    dl = sda_pull_low;
    line = sda_in;
    bit_strobe = 1'b1;
    @(negedge clk);
    bit_strobe = 1'b0; m_low = 1'b0; o_low = 1'b0;
  endtask

  // Full transfer; drv[0] = acknowledge, drv[1..7] = address bits, drv[8] = trailing bit.
  task automatic xfer(input logic [6:0] maddr, input logic rw,
                      input logic [6:0] other, input logic other_on,
                      output logic [8:0] d);
    logic o_eng, o_lost, dl, line, ol;
    d = '0;
    o_eng = other_on && (maddr == ARA) && rw;
    o_lost = 1'b0;
    do_start();
    for (int b = 0; b < 18; b++) begin
      ol = 1'b0;
      if (b == 8) ol = o_eng;
      else if (b >= 9 && b <= 15) ol = o_eng && !o_lost && !other[15 - b];
      if (b < 7)       one_bit(~maddr[6 - b], ol, dl, line);
      else if (b == 7) one_bit(~rw, ol, dl, line);
      else             one_bit(1'b0, ol, dl, line);
      if (b >= 9 && b <= 16 && o_eng && !ol && !line) o_lost = 1'b1;
      if (b >= 8 && b <= 16) d[b - 8] = dl;
    end
    do_stop();
  endtask

  function automatic logic [8:0] win_pattern(input logic [6:0] a);
    logic [8:0] p;
    p[0] = 1'b1;
    for (int i = 0; i < 7; i++) p[1 + i] = ~a[6 - i];
    p[8] = 1'b0;
    return p;
  endfunction

  initial begin
    fork
      begin
        do_reset(7'h4D);
        @(negedge clk);
        check("R1 reset alert", {15'd0, alert_pull_low}, 16'd0);
        check("R1 reset sda", {15'd0, sda_pull_low}, 16'd0);

        // R1 set by high crossing, R2 holds through clean conversions
        convert(1, 0, 0);
        check("R1 high sets", {15'd0, alert_pull_low}, 16'd1);
        convert(0, 0, 0);
        convert(0, 0, 0);
        check("R2 holds", {15'd0, alert_pull_low}, 16'd1);

        // R5 wrong address and write direction
        xfer(7'h0D, 1'b1, 7'h00, 1'b0, drv);
        check("R5 wrong addr drive", {7'd0, drv}, 16'd0);
        xfer(ARA, 1'b0, 7'h00, 1'b0, drv);
        check("R5 write drive", {7'd0, drv}, 16'd0);
        check("R5 latch kept", {15'd0, alert_pull_low}, 16'd1);

        // R3 winning read
        xfer(ARA, 1'b1, 7'h00, 1'b0, drv);
        check("R3 response bits", {7'd0, drv}, {7'd0, win_pattern(7'h4D)});
        check("R2 win clears", {15'd0, alert_pull_low}, 16'd0);

        // R11 no pending
        xfer(ARA, 1'b1, 7'h00, 1'b0, drv);
        check("R11 no response", {7'd0, drv}, 16'd0);

        // R6 high once per crossing
        convert(1, 0, 0);
        check("R6 high not rearmed", {15'd0, alert_pull_low}, 16'd0);
        pulse_hi_wr();
        convert(1, 0, 0);
        check("R6 high rearmed", {15'd0, alert_pull_low}, 16'd1);
        xfer(ARA, 1'b1, 7'h00, 1'b0, drv);
        // R6 low channel
        convert(0, 1, 0);
        check("R6 low sets", {15'd0, alert_pull_low}, 16'd1);
        xfer(ARA, 1'b1, 7'h00, 1'b0, drv);
        convert(0, 1, 0);
        check("R6 low not rearmed", {15'd0, alert_pull_low}, 16'd0);
        pulse_hi_wr();
        convert(0, 1, 0);
        check("R6 other write no rearm", {15'd0, alert_pull_low}, 16'd0);
        pulse_lo_wr();
        convert(0, 1, 0);
        check("R6 low rearmed", {15'd0, alert_pull_low}, 16'd1);
        xfer(ARA, 1'b1, 7'h00, 1'b0, drv);

        // R7 fault episodes
        convert(0, 0, 1);
        check("R7 fault sets", {15'd0, alert_pull_low}, 16'd1);
        xfer(ARA, 1'b1, 7'h00, 1'b0, drv);
        convert(0, 0, 1);
        check("R7 fault persists no refire", {15'd0, alert_pull_low}, 16'd0);
        convert(0, 0, 0);
        convert(0, 0, 1);
        check("R7 fault refires", {15'd0, alert_pull_low}, 16'd1);
        xfer(ARA, 1'b1, 7'h00, 1'b0, drv);

        // R8 mask
        pulse_lo_wr();
        alert_mask = 1'b1;
        convert(0, 1, 0);
        check("R8 masked no set", {15'd0, alert_pull_low}, 16'd0);
        alert_mask = 1'b0;
        convert(0, 1, 0);
        check("R8 arming kept", {15'd0, alert_pull_low}, 16'd1);
        alert_mask = 1'b1;
        convert(0, 0, 0);
        check("R8 latch kept under mask", {15'd0, alert_pull_low}, 16'd1);
        alert_mask = 1'b0;

        // R4 lose to 0x4C, then win against 0x4E
        xfer(ARA, 1'b1, 7'h4C, 1'b1, drv);
        check("R4 loser stops", {15'd0, drv[8]}, 16'd0);
        check("R4 loser keeps alert", {15'd0, alert_pull_low}, 16'd1);
        check("R4 bits before loss", {9'd0, drv[6:0]}, {9'd0, win_pattern(7'h4D) & 9'h07F});
        xfer(ARA, 1'b1, 7'h4E, 1'b1, drv);
        check("R4 winner clears", {15'd0, alert_pull_low}, 16'd0);

        // R10 aborted transfer and repeated start
        convert(0, 0, 1);
        convert(0, 0, 0);
        convert(0, 0, 1);
        do_start();
        for (int b = 0; b < 3; b++) begin
          logic dl, ln;
          one_bit(1'b0, 1'b0, dl, ln);
        end
        do_stop();
        check("R10 abort keeps alert", {15'd0, alert_pull_low}, 16'd1);
        do_start();
        for (int b = 0; b < 4; b++) begin
          logic dl, ln;
          one_bit(1'b1, 1'b0, dl, ln);
        end
        xfer(ARA, 1'b1, 7'h00, 1'b0, drv);
        check("R10 restart bits", {7'd0, drv}, {7'd0, win_pattern(7'h4D)});

        // R9 own address captured at reset only
        do_reset(7'h21);
        own_addr_in = 7'h5A;
        convert(1, 0, 0);
        xfer(ARA, 1'b1, 7'h00, 1'b0, drv);
        check("R9 captured addr", {7'd0, drv}, {7'd0, win_pattern(7'h21)});

        // R3 sweep over strapped addresses
        for (int k = 0; k < 8; k++) begin
          logic [6:0] a;
          a = 7'((k * 37 + 5) % 128);
          do_reset(a);
          convert(1, 0, 0);
          xfer(ARA, 1'b1, 7'h00, 1'b0, drv);
          check("R3 sweep bits", {7'd0, drv}, {7'd0, win_pattern(a)});
          check("R2 sweep clears", {15'd0, alert_pull_low}, 16'd0);
        end

        // R5 sweep of all master addresses with latch set
        do_reset(7'h33);
        convert(1, 0, 0);
        for (int a = 0; a < 128; a++) begin
          if (7'(a) != ARA) begin
            xfer(7'(a), 1'b1, 7'h00, 1'b0, drv);
            check("R5 sweep no drive", {7'd0, drv}, 16'd0);
            check("R5 sweep alert", {15'd0, alert_pull_low}, 16'd1);
          end
        end
      end
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule